// File: doc/BRIEF.md
# Lane-Split Population Count and Byte Parity Unit

This unit takes one 64-bit operand and either counts its set bits or forms a parity from the lowest bit of each byte. A size code splits the operand into lanes: one lane of eight bytes, two lanes of four bytes, or eight lanes of one byte. Every lane's result is written inside that lane's own bit range, and the result is zero-extended to fill the lane. Parity looks only at bit 0 of each byte. The count has a byte form. Parity does not.

An opaque context word travels alongside the operand and comes out unchanged, so a surrounding pipeline can carry the operation's tag through the unit. A valid flag marks whether a recognised function was selected. An optional output register stage is set by the `REG_OUT` parameter. With the default `REG_OUT = 1`, the result, the flag and the context all appear one clock after the inputs.

Top module: `lane_popcount_parity`

## Requirements
- R1: With function code 2'b01 (count) and size code 4'd8, the result equals the number of set bits among all 64 operand bits, and bits 63:7 are zero.
- R2: With function code 2'b01 and size code 4'd4, result bits 31:0 hold the set-bit count of operand bits 31:0, and result bits 63:32 hold the count of operand bits 63:32. Each count is zero-extended within its half.
- R3: With function code 2'b01 and size code 4'd1, each result byte k (bits 8k+7:8k) holds the set-bit count of operand byte k, zero-extended.
- R4: With function code 2'b10 (parity) and size code 4'd8, result bit 0 is the XOR of operand bits 0, 8, 16, ..., 56, and all other result bits are zero.
- R5: With function code 2'b10 and size code 4'd4, result bit 0 is the XOR of operand bits 0, 8, 16 and 24, and result bit 32 is the XOR of operand bits 32, 40, 48 and 56. All other result bits are zero.
- R6: The context output equals the context input that was presented with the same operation.
- R7: The valid flag is 1 for function codes 2'b01 and 2'b10, and 0 for 2'b00 and 2'b11. When the flag is 0, the result is zero.
- R8: A size code that is not defined for the selected function gives a zero result with the valid flag set to 1. The undefined cases include parity with 4'd1, and any size code other than 4'd1, 4'd4 and 4'd8.
- R9: With `REG_OUT = 1`, the outputs reflect the inputs sampled at the previous rising clock edge. A rising edge with `rst_n` low clears the result, the valid flag and the context to zero.
- R10: Parity ignores every operand bit that is not bit 0 of a byte. Setting only such bits leaves a parity result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_operand | input | DATA_W | Operand to count or check |
| in_op | input | 2 | Function code: 2'b01 count, 2'b10 parity, other values are no operation |
| in_size | input | 4 | Lane size in bytes: 4'd8, 4'd4 or 4'd1 |
| in_ctx | input | CTX_W | Opaque context carried through |
| out_result | output | DATA_W | Lane-formatted result |
| out_valid | output | 1 | High when a recognised function was selected |
| out_ctx | output | CTX_W | Context output, equal to the context input |

## Verification
The bench builds the unit with its defaults: a 64-bit operand, a 16-bit context and the register stage enabled. With these values, the eight-byte, two-half and single-byte lane splits all exist together. This lets the bench check full-width counts up to 64, half counts up to 32 and byte counts up to 8. Because the register stage is present, the bench can also check the one-cycle latency and the synchronous clear. Stimuli combine all-zero, all-one and single-bit operands with patterns that set only the bits parity must ignore, plus random traffic across every function and size code.

// File: rtl/lpp_pkg.sv
// Shared definitions for the lane-split count/parity unit.
// Assumes the operand width is a multiple of 16 bits (an even number of bytes).
package lpp_pkg;

    // Function selector values
    typedef enum logic [1:0] {
        LPP_OP_NONE   = 2'b00,
        LPP_OP_POPCNT = 2'b01,
        LPP_OP_PARITY = 2'b10,
        LPP_OP_RSVD   = 2'b11
    } lpp_op_e;

    // Lane size codes, in bytes per lane
    localparam logic [3:0] LPP_SZ_BYTE  = 4'd1;
    localparam logic [3:0] LPP_SZ_HALF  = 4'd4;
    localparam logic [3:0] LPP_SZ_WHOLE = 4'd8;

    localparam int LPP_BYTE_W = 8;

endpackage

// File: rtl/lpp_byte_count.sv
// Counts the set bits of one byte-sized slice.
// Assumes BYTE_W is small; the adder chain is BYTE_W deep.
module lpp_byte_count #(
    parameter int BYTE_W = 8,
    localparam int CW = $clog2(BYTE_W + 1)
) (
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CW-1:0]     count
);

    // Add each bit of the slice into the running count
    always_comb begin
        count = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            count = count + CW'(byte_in[i]);
        end
    end

endmodule

// File: rtl/lpp_popcount.sv
// Builds the set-bit counts for all three lane splits at once.
// It outputs byte lanes, half lanes and one whole-width lane, each zero-extended
// within its lane. Assumes DATA_W is a multiple of 16.
module lpp_popcount
    import lpp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] res_byte,
    output logic [DATA_W-1:0] res_half,
    output logic [DATA_W-1:0] res_whole
);

    localparam int NB     = DATA_W / LPP_BYTE_W;
    localparam int NB_H   = NB / 2;
    localparam int HALF_W = DATA_W / 2;
    localparam int BCW    = $clog2(LPP_BYTE_W + 1);
    localparam int HCW    = $clog2(HALF_W + 1);
    localparam int FCW    = $clog2(DATA_W + 1);

    logic [BCW-1:0] byte_cnt [NB];
    logic [HCW-1:0] half_cnt [2];
    logic [FCW-1:0] whole_cnt;

    // One counter per byte, each placed back into its own byte lane
    for (genvar g = 0; g < NB; g++) begin : g_byte
        lpp_byte_count #(.BYTE_W(LPP_BYTE_W)) u_cnt (
            .byte_in (operand[g*LPP_BYTE_W +: LPP_BYTE_W]),
            .count   (byte_cnt[g])
        );
        assign res_byte[g*LPP_BYTE_W +: LPP_BYTE_W] = LPP_BYTE_W'(byte_cnt[g]);
    end

    // Sum the byte counts into half counts and then into the whole count
    always_comb begin
        for (int h = 0; h < 2; h++) begin
            half_cnt[h] = '0;
            for (int b = 0; b < NB_H; b++) begin
                half_cnt[h] = half_cnt[h] + HCW'(byte_cnt[h*NB_H + b]);
            end
        end
        whole_cnt = FCW'(half_cnt[0]) + FCW'(half_cnt[1]);
    end

    // Place each half count, zero-extended, in its half lane
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign res_half[h*HALF_W +: HALF_W] = HALF_W'(half_cnt[h]);
    end

    assign res_whole = DATA_W'(whole_cnt);

endmodule

// File: rtl/lpp_parity.sv
// Forms parity from the lowest bit of each byte, for the half split and the whole split.
// Receives only the byte-lsb vector, so no other operand bit can reach it.
module lpp_parity #(
    parameter int NB = 8
) (
    input  logic [NB-1:0]   byte_lsb,
    output logic [NB*8-1:0] res_half,
    output logic [NB*8-1:0] res_whole
);

    localparam int NB_H   = NB / 2;
    localparam int HALF_W = NB * 4;

    // Reduce each half's lsbs into bit 0 of that half lane
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign res_half[h*HALF_W +: HALF_W] = HALF_W'(^byte_lsb[h*NB_H +: NB_H]);
    end

    // Reduce all lsbs into result bit 0
    assign res_whole = (NB*8)'(^byte_lsb);

endmodule

// File: rtl/lane_popcount_parity.sv
// Top of the lane-split count/parity unit. It chooses between the function and
// size variants, carries the context word through, and can register the outputs.
// Assumes DATA_W is a multiple of 16. The clocked checks cover REG_OUT = 1.
module lane_popcount_parity
    import lpp_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int CTX_W   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_operand,
    input  logic [1:0]        in_op,
    input  logic [3:0]        in_size,
    input  logic [CTX_W-1:0]  in_ctx,
    output logic [DATA_W-1:0] out_result,
    output logic              out_valid,
    output logic [CTX_W-1:0]  out_ctx
);

    localparam int NB = DATA_W / LPP_BYTE_W;

    lpp_op_e           op_sel;
    logic [NB-1:0]     byte_lsb;
    logic [DATA_W-1:0] pc_byte, pc_half, pc_whole;
    logic [DATA_W-1:0] par_half, par_whole;
    logic [DATA_W-1:0] nxt_result;
    logic              nxt_valid;

    assign op_sel = lpp_op_e'(in_op);

    // Gather bit 0 of every byte for the parity path
    for (genvar g = 0; g < NB; g++) begin : g_lsb
        assign byte_lsb[g] = in_operand[g*LPP_BYTE_W];
    end

    lpp_popcount #(.DATA_W(DATA_W)) u_popcount (
        .operand   (in_operand),
        .res_byte  (pc_byte),
        .res_half  (pc_half),
        .res_whole (pc_whole)
    );

    lpp_parity #(.NB(NB)) u_parity (
        .byte_lsb  (byte_lsb),
        .res_half  (par_half),
        .res_whole (par_whole)
    );

    // Pick the result for the selected function and size; zero if the size is undefined
    always_comb begin
        nxt_result = '0;
        nxt_valid  = 1'b0;
        case (op_sel)
            LPP_OP_POPCNT: begin
                nxt_valid = 1'b1;
                case (in_size)
                    LPP_SZ_BYTE:  nxt_result = pc_byte;
                    LPP_SZ_HALF:  nxt_result = pc_half;
                    LPP_SZ_WHOLE: nxt_result = pc_whole;
                    default:      nxt_result = '0;
                endcase
            end
            LPP_OP_PARITY: begin
                nxt_valid = 1'b1;
                case (in_size)
                    LPP_SZ_HALF:  nxt_result = par_half;
                    LPP_SZ_WHOLE: nxt_result = par_whole;
                    default:      nxt_result = '0;
                endcase
            end
            default: begin
                nxt_valid  = 1'b0;
                nxt_result = '0;
            end
        endcase
    end

    if (REG_OUT) begin : g_reg
        // Output register stage with synchronous active-low clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_result <= '0;
                out_valid  <= 1'b0;
                out_ctx    <= '0;
            end else begin
                out_result <= nxt_result;
                out_valid  <= nxt_valid;
                out_ctx    <= in_ctx;
            end
        end

        // R6: context leaves exactly as it arrived, one cycle later
        p_ctx_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> out_ctx == $past(in_ctx));

        // R7: flag follows whether the function code was a recognised one
        p_valid_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> out_valid == ($past(in_op) == 2'b01 || $past(in_op) == 2'b10));

        // R7: result is zero whenever the flag is low
        p_invalid_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid |-> out_result == '0);

        // R1: a whole-width count never exceeds the operand width
        p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_op) == 2'b01 && $past(in_size) == 4'd8)
            |-> out_result <= DATA_W);

        // R4: whole-width parity only ever drives bit 0
        p_parity_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_op) == 2'b10 && $past(in_size) == 4'd8)
            |-> out_result[DATA_W-1:1] == '0);

        // R8: parity with a byte split is undefined: zero result, flag still high
        p_undef_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_op) == 2'b10 && $past(in_size) == 4'd1)
            |-> (out_result == '0 && out_valid));

        // R9: a clearing edge leaves all outputs at zero
        p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> (out_result == '0 && !out_valid && out_ctx == '0));
    end else begin : g_comb
        // Purely combinational outputs
        assign out_result = nxt_result;
        assign out_valid  = nxt_valid;
        assign out_ctx    = in_ctx;
    end

endmodule

// File: tb/lane_popcount_parity_bench.sv
module lane_popcount_parity_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] in_operand = '0;
    logic [1:0]  in_op = '0;
    logic [3:0]  in_size = '0;
    logic [15:0] in_ctx = '0;
    logic [63:0] out_result;
    logic        out_valid;
    logic [15:0] out_ctx;

    int total = 0;
    int bad = 0;

    logic [63:0] q_res[$];
    logic        q_val[$];
    logic [15:0] q_ctx[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    lane_popcount_parity #(.DATA_W(64), .CTX_W(16), .REG_OUT(1'b1)) u_lane_popcount_parity (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_operand (in_operand),
        .in_op      (in_op),
        .in_size    (in_size),
        .in_ctx     (in_ctx),
        .out_result (out_result),
        .out_valid  (out_valid),
        .out_ctx    (out_ctx)
    );

    // Behavioural model: bits are added or XORed one at a time
    function automatic void ref_calc(input logic [63:0] a, input logic [1:0] op,
                                     input logic [3:0] sz,
                                     output logic [63:0] r, output logic v);
        int n;
        logic p;
        r = '0;
        v = 1'b0;
        if (op == 2'b01) begin
            v = 1'b1;
            if (sz == 4'd8) begin
                n = 0;
                for (int i = 0; i < 64; i++) n += int'(a[i]);
                r = 64'(n);
            end else if (sz == 4'd4) begin
                for (int h = 0; h < 2; h++) begin
                    n = 0;
                    for (int i = 0; i < 32; i++) n += int'(a[h*32+i]);
                    r[h*32 +: 32] = n[31:0];
                end
            end else if (sz == 4'd1) begin
                for (int b = 0; b < 8; b++) begin
                    n = 0;
                    for (int i = 0; i < 8; i++) n += int'(a[b*8+i]);
                    r[b*8 +: 8] = n[7:0];
                end
            end
        end else if (op == 2'b10) begin
            v = 1'b1;
            if (sz == 4'd8) begin
                p = 1'b0;
                for (int k = 0; k < 8; k++) p = p ^ a[k*8];
                r[0] = p;
            end else if (sz == 4'd4) begin
                for (int h = 0; h < 2; h++) begin
                    p = 1'b0;
                    for (int k = 0; k < 4; k++) p = p ^ a[h*32 + k*8];
                    r[h*32] = p;
                end
            end
        end
    endfunction

    function automatic string tag_of(input logic [1:0] op, input logic [3:0] sz);
        if (op == 2'b01 && sz == 4'd8) return "R1";
        if (op == 2'b01 && sz == 4'd4) return "R2";
        if (op == 2'b01 && sz == 4'd1) return "R3";
        if (op == 2'b10 && sz == 4'd8) return "R4";
        if (op == 2'b10 && sz == 4'd4) return "R5";
        if (op == 2'b00 || op == 2'b11) return "R7";
        return "R8";
    endfunction

    // Compare the outputs against the oldest queued expectation
    task automatic check_pending();
        logic [63:0] er;
        logic        ev;
        logic [15:0] ec;
        string       t;
        if (q_res.size() > 0) begin
            er = q_res.pop_front();
            ev = q_val.pop_front();
            ec = q_ctx.pop_front();
            t  = q_tag.pop_front();
            total++;
            if (out_result !== er || out_valid !== ev) begin
                bad++;
                $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
                         t, out_result, out_valid, er, ev);
            end
            total++;
            if (out_ctx !== ec) begin
                bad++;
                $display("FAIL R6 (%s): ctx=%h expected %h", t, out_ctx, ec);
            end
        end
    endtask

    // Drive one operation at the falling edge and queue its expected outputs
    task automatic step(input logic [63:0] a, input logic [1:0] op,
                        input logic [3:0] sz, input string t);
        logic [63:0] er;
        logic        ev;
        @(negedge clk);
        check_pending();
        in_operand = a;
        in_op      = op;
        in_size    = sz;
        in_ctx     = 16'($urandom());
        ref_calc(a, op, sz, er, ev);
        q_res.push_back(er);
        q_val.push_back(ev);
        q_ctx.push_back(in_ctx);
        q_tag.push_back(t);
    endtask

    // R9: hold reset for one edge while a valid operation is presented
    task automatic reset_check();
        @(negedge clk);
        check_pending();
        rst_n      = 1'b0;
        in_operand = '1;
        in_op      = 2'b01;
        in_size    = 4'd8;
        in_ctx     = 16'hBEEF;
        @(negedge clk);
        total++;
        if (out_result !== '0 || out_valid !== 1'b0 || out_ctx !== '0) begin
            bad++;
            $display("FAIL R9: result=%h valid=%b ctx=%h expected all zero",
                     out_result, out_valid, out_ctx);
        end
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [1:0] rop;
        logic [3:0] rsz;
        logic [63:0] rv;
        in_operand = 64'hFFFF_0000_1234_5678;
        in_op      = 2'b01;
        repeat (3) @(posedge clk);
        reset_check();                                        // R9 from start

        // R1: whole-width count
        step(64'h0, 2'b01, 4'd8, "R1");
        step('1, 2'b01, 4'd8, "R1");
        step(64'h8000_0000_0000_0000, 2'b01, 4'd8, "R1");
        step(64'h1, 2'b01, 4'd8, "R1");
        for (int i = 0; i < 4; i++) step({$urandom(), $urandom()}, 2'b01, 4'd8, "R1");
        // R2: half counts
        step('1, 2'b01, 4'd4, "R2");
        step(64'hFFFF_FFFF_0000_0000, 2'b01, 4'd4, "R2");
        step(64'h0000_0001_8000_0000, 2'b01, 4'd4, "R2");
        for (int i = 0; i < 4; i++) step({$urandom(), $urandom()}, 2'b01, 4'd4, "R2");
        // R3: byte counts
        step('1, 2'b01, 4'd1, "R3");
        step(64'h0103_070F_1F3F_7FFF, 2'b01, 4'd1, "R3");
        step(64'h0, 2'b01, 4'd1, "R3");
        for (int i = 0; i < 4; i++) step({$urandom(), $urandom()}, 2'b01, 4'd1, "R3");
        // R4: whole parity
        step(64'h0101_0101_0101_0101, 2'b10, 4'd8, "R4");
        step(64'h0000_0000_0000_0001, 2'b10, 4'd8, "R4");
        step(64'h0100_0000_0000_0000, 2'b10, 4'd8, "R4");
        for (int i = 0; i < 4; i++) step({$urandom(), $urandom()}, 2'b10, 4'd8, "R4");
        // R5: half parity
        step(64'h0000_0001_0000_0001, 2'b10, 4'd4, "R5");
        step(64'h0101_0100_0000_0001, 2'b10, 4'd4, "R5");
        for (int i = 0; i < 4; i++) step({$urandom(), $urandom()}, 2'b10, 4'd4, "R5");
        // R10: only non-lsb byte bits set, parity must be zero
        step(64'hFEFE_FEFE_FEFE_FEFE, 2'b10, 4'd8, "R10");
        step(64'hFEFE_FEFE_FEFE_FEFE, 2'b10, 4'd4, "R10");
        // R7: unrecognised function codes
        step('1, 2'b00, 4'd8, "R7");
        step('1, 2'b11, 4'd1, "R7");
        // R8: undefined size codes
        step('1, 2'b10, 4'd1, "R8");
        step('1, 2'b01, 4'd2, "R8");
        step('1, 2'b10, 4'd0, "R8");
        step('1, 2'b01, 4'd15, "R8");
        // R9: clear in mid-run
        reset_check();
        // Mixed random traffic, back to back
        for (int i = 0; i < 60; i++) begin
            rop = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 4))
                0: rsz = 4'd1;
                1: rsz = 4'd4;
                2: rsz = 4'd8;
                default: rsz = 4'($urandom());
            endcase
            rv = {$urandom(), $urandom()};
            step(rv, rop, rsz, tag_of(rop, rsz));
        end
        @(negedge clk);
        check_pending();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule